// File: doc/BRIEF.md
# Partitioned Victim Page Buffer

This block sits beside a set-associative main memory that caches pages from a slower non-volatile backing store. It catches pages evicted from that memory. For each page it keeps the address space identifier, the page tag and a bitmap of subpages that are still dirty. Page data lives elsewhere. The buffer keeps only the state needed to find a page and to decide which subpages still have to go back to the store. A lookup runs alongside the main memory's own tag search. On a hit, the page and its remaining dirty bits are handed back to main memory, and the entry leaves the buffer.

The slots are ordered by age, from slot 0 (the newest) to the last slot (the oldest). A programmable threshold splits them into two regions. Slots below the threshold form a write-through region. Its dirty subpages are sent to the store in the background whenever the store channel reports idle. Slots at or above the threshold form a write-back region, whose pages are held dirty until they fall off the end. When the buffer is full and its oldest page still has dirty subpages, an insert is held off. The oldest page's subpages are then copied back at once, and the insert goes ahead when the page is clean.

Top module: `victim_page_buf`

## Requirements
- R1: After reset the buffer is empty, `ins_ready` is 1, `cb_valid` and `rs_valid` are 0, and the threshold equals ENTRIES/4.
- R2: An accepted insert places the new page in slot 0, and every held page moves one slot older.
- R3: A lookup (`lk_valid`) hits when a held page matches both `lk_asid` and `lk_tag`. Its result appears on the `rs_*` outputs exactly HIT_LAT cycles later. A miss reports `rs_hit`=0, `rs_slot`=0 and `rs_dirty`=0.
- R4: A hit reports the page's slot at lookup time and removes the page. Older pages each move one slot younger, and younger pages keep their slots.
- R5: While `chan_idle` is 1 and no displacement is pending, `cb_valid` requests the lowest-numbered dirty subpage (`cb_sub` is the bit index) of the oldest page in a slot below the threshold. A transfer is taken when `cb_valid` and `cb_ready` are both 1, and it clears that dirty bit.
- R6: No background request is made while `chan_idle` is 0, or when the only dirty pages sit at or above the threshold.
- R7: When the last slot holds a page with dirty bits, `ins_ready` is 0. While `ins_valid` is 1, requests for that page's subpages are made whatever the value of `chan_idle`. Once the page is clean, the insert is accepted and that page is dropped.
- R8: `cfg_we` loads `cfg_wt` as the new threshold, and the new value takes effect from the next cycle.
- R9: When a subpage transfer and a hit on the same page happen in one cycle, the returned bitmap no longer holds the transferred bit.
- R10: An insert and a hit in the same cycle both take effect. The hit page is removed first, and then the new page enters slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a new threshold |
| cfg_wt | input | CNT_W | Threshold: the number of write-through slots |
| ins_valid | input | 1 | Evicted page offered |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_asid | input | ASID_W | Address space of the offered page |
| ins_tag | input | TAG_W | Tag of the offered page |
| ins_dirty | input | SUB | Dirty subpage bitmap of the offered page |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address space |
| lk_tag | input | TAG_W | Lookup tag |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Lookup hit |
| rs_slot | output | IDX_W | Slot of the hit page |
| rs_dirty | output | SUB | Remaining dirty bitmap of the hit page |
| chan_idle | input | 1 | Backing-store channel idle |
| cb_valid | output | 1 | Copy-back request |
| cb_ready | input | 1 | Copy-back transfer accepted |
| cb_asid | output | ASID_W | Address space of the page being copied back |
| cb_tag | output | TAG_W | Tag of the page being copied back |
| cb_sub | output | SUB_W | Subpage index being copied back |

## Verification
Three actions can land in the same cycle: an accepted copy-back that clears a dirty bit, a lookup hit that pulls out the same page, and an insert that shifts every slot. The bench often steers its lookup at the page that the copy-back port is pointing at, while `cb_ready` is high and an insert is offered. It then checks that the returned bitmap, three cycles later, lacks the transferred bit. It also checks that the slot ordering afterwards shows up in the slots that later hits report. A bench model applies the clear, then the removal, then the insert, and every output is compared with that model on every cycle.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
    // Which rule chose the current copy-back target
    typedef enum logic [1:0] {
        CB_NONE       = 2'd0,
        CB_BACKGROUND = 2'd1,
        CB_DISPLACE   = 2'd2
    } cb_src_e;
endpackage

// File: rtl/vpb_match.sv
module vpb_match #(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 28,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0][KEY_W-1:0] key_i,
    input  logic [KEY_W-1:0]              probe_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    // Associative compare; keys held are unique, so at most one matches
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_i[i] && key_i[i] == probe_i) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpb_pick.sv
module vpb_pick #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0] dirty_i,
    input  logic [CNT_W-1:0]   wt_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Oldest dirty slot inside the write-through region (highest index below wt)
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (dirty_i[i] && (CNT_W'(i) < wt_i)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpb_respipe.sv
module vpb_respipe #(
    parameter int LAT = 3,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [LAT-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < LAT; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[LAT-1];
endmodule

// File: rtl/victim_page_buf.sv
module victim_page_buf
    import vpb_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int SUB     = 8,
    parameter int ASID_W  = 8,
    parameter int TAG_W   = 20,
    parameter int HIT_LAT = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int SUB_W  = $clog2(SUB),
    localparam int KEY_W  = ASID_W + TAG_W,
    localparam int RES_W  = 2 + IDX_W + SUB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_wt,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [SUB-1:0]    ins_dirty,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [IDX_W-1:0]  rs_slot,
    output logic [SUB-1:0]    rs_dirty,
    input  logic              chan_idle,
    output logic              cb_valid,
    input  logic              cb_ready,
    output logic [ASID_W-1:0] cb_asid,
    output logic [TAG_W-1:0]  cb_tag,
    output logic [SUB_W-1:0]  cb_sub
);
    localparam logic [CNT_W-1:0] WT_RESET = CNT_W'(ENTRIES / 4);
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic              v;
        logic [ASID_W-1:0] asid;
        logic [TAG_W-1:0]  tag;
        logic [SUB-1:0]    dirty;
    } ent_t;

    typedef ent_t [ENTRIES-1:0] ent_arr_t;

    typedef struct packed {
        ent_arr_t         ent;
        logic [CNT_W-1:0] wt;
    } state_t;

    state_t st_d, st_q;

    // Per-slot views feeding the search and pick logic
    logic [ENTRIES-1:0]            vld_w;
    logic [ENTRIES-1:0]            dz_w;
    logic [ENTRIES-1:0][KEY_W-1:0] key_w;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign vld_w[g] = st_q.ent[g].v;
        assign dz_w[g]  = st_q.ent[g].v && (|st_q.ent[g].dirty);
        assign key_w[g] = {st_q.ent[g].asid, st_q.ent[g].tag};
    end

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             bg_found;
    logic [IDX_W-1:0] bg_idx;

    vpb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
        .vld_i  (vld_w),
        .key_i  (key_w),
        .probe_i({lk_asid, lk_tag}),
        .hit_o  (m_hit),
        .idx_o  (m_idx)
    );

    vpb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .dirty_i(dz_w),
        .wt_i   (st_q.wt),
        .found_o(bg_found),
        .idx_o  (bg_idx)
    );

    // Copy-back target selection
    logic             oldest_dirty;
    cb_src_e          cb_src;
    logic [IDX_W-1:0] tgt_idx;
    ent_t             tgt_ent;
    logic [SUB_W-1:0] tgt_sub;

    assign oldest_dirty = dz_w[ENTRIES-1];
    assign ins_ready    = !oldest_dirty;

    always_comb begin
        if (ins_valid && oldest_dirty) begin
            cb_src  = CB_DISPLACE;
            tgt_idx = LAST;
        end else if (chan_idle && bg_found) begin
            cb_src  = CB_BACKGROUND;
            tgt_idx = bg_idx;
        end else begin
            cb_src  = CB_NONE;
            tgt_idx = '0;
        end
        tgt_ent = st_q.ent[tgt_idx];
        tgt_sub = '0;
        for (int s = SUB - 1; s >= 0; s--) begin
            if (tgt_ent.dirty[s]) tgt_sub = SUB_W'(s);
        end
    end

    assign cb_valid = (cb_src != CB_NONE);
    assign cb_asid  = tgt_ent.asid;
    assign cb_tag   = tgt_ent.tag;
    assign cb_sub   = tgt_sub;

    // Next-state: clear copied bit, then remove hit, then insert
    logic             cb_fire;
    logic             hit_w;
    logic             ins_fire;
    ent_arr_t         work;
    ent_arr_t         rem;
    logic [SUB-1:0]   hit_dirty;
    logic [RES_W-1:0] res_in;
    logic [RES_W-1:0] res_out;

    assign cb_fire  = cb_valid && cb_ready;
    assign hit_w    = lk_valid && m_hit;
    assign ins_fire = ins_valid && ins_ready;

    always_comb begin
        st_d = st_q;
        work = st_q.ent;
        if (cb_fire) work[tgt_idx].dirty[tgt_sub] = 1'b0;
        hit_dirty = work[m_idx].dirty;

        rem = work;
        if (hit_w) begin
            for (int i = 0; i < ENTRIES - 1; i++) begin
                if (IDX_W'(i) >= m_idx) rem[i] = work[i+1];
            end
            rem[ENTRIES-1] = '0;
        end

        if (ins_fire) begin
            st_d.ent[0] = '{v: 1'b1, asid: ins_asid, tag: ins_tag, dirty: ins_dirty};
            for (int i = 1; i < ENTRIES; i++) begin
                st_d.ent[i] = rem[i-1];
            end
        end else begin
            st_d.ent = rem;
        end

        if (cfg_we) st_d.wt = cfg_wt;

        res_in = {lk_valid, hit_w,
                  hit_w ? m_idx : {IDX_W{1'b0}},
                  hit_w ? hit_dirty : {SUB{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ent <= '0;
            st_q.wt  <= WT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    vpb_respipe #(.LAT(HIT_LAT), .W(RES_W)) u_res (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (res_in),
        .dout (res_out)
    );

    assign {rs_valid, rs_hit, rs_slot, rs_dirty} = res_out;
endmodule

// File: rtl/vpb_chk.sv
module vpb_chk #(
    parameter int IDX_W = 7,
    parameter int SUB   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             chan_idle,
    input logic             cb_valid,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic [IDX_W-1:0] rs_slot,
    input logic [SUB-1:0]   rs_dirty
);
    // R7
    displace_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready) |-> cb_valid);

    // R6
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_valid && !chan_idle) |-> (ins_valid && !ins_ready));

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_slot == '0 && rs_dirty == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rs_valid && ins_ready));
endmodule

bind victim_page_buf vpb_chk #(.IDX_W(IDX_W), .SUB(SUB)) u_vpb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_valid(ins_valid),
    .ins_ready(ins_ready),
    .chan_idle(chan_idle),
    .cb_valid (cb_valid),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_slot  (rs_slot),
    .rs_dirty (rs_dirty)
);

// File: tb/tb_victim_page_buf.sv
module tb_victim_page_buf;
    localparam int E   = 4;
    localparam int SB  = 4;
    localparam int AW  = 2;
    localparam int TW  = 3;
    localparam int LAT = 3;
    localparam int IW  = 2;
    localparam int CW  = 3;
    localparam int SW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_wt = '0;
    logic          ins_valid = 1'b0;
    logic          ins_ready;
    logic [AW-1:0] ins_asid = '0;
    logic [TW-1:0] ins_tag = '0;
    logic [SB-1:0] ins_dirty = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_asid = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          rs_valid, rs_hit;
    logic [IW-1:0] rs_slot;
    logic [SB-1:0] rs_dirty;
    logic          chan_idle = 1'b0;
    logic          cb_valid;
    logic          cb_ready = 1'b0;
    logic [AW-1:0] cb_asid;
    logic [TW-1:0] cb_tag;
    logic [SW-1:0] cb_sub;

    always #4 clk = ~clk;

    victim_page_buf #(.ENTRIES(E), .SUB(SB), .ASID_W(AW), .TAG_W(TW), .HIT_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wt(cfg_wt),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_asid(ins_asid),
        .ins_tag(ins_tag), .ins_dirty(ins_dirty),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_tag(lk_tag),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_slot(rs_slot), .rs_dirty(rs_dirty),
        .chan_idle(chan_idle), .cb_valid(cb_valid), .cb_ready(cb_ready),
        .cb_asid(cb_asid), .cb_tag(cb_tag), .cb_sub(cb_sub)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the requirements
    logic [AW-1:0] ma [E];
    logic [TW-1:0] mt [E];
    logic [SB-1:0] md [E];
    int            cnt = 0;
    int            wt  = E / 4;
    int            key_ctr = 0;
    // expected result pipeline
    logic          pv [LAT];
    logic          ph [LAT];
    int            ps [LAT];
    logic [SB-1:0] pd [LAT];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit present(logic [AW-1:0] a, logic [TW-1:0] t);
        for (int i = 0; i < cnt; i++) if (ma[i] == a && mt[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(int p_ins, int p_idle, int p_lk);
        bit e_ready, e_cbv, disp, hit;
        int tgt, esub, hi;
        logic [SB-1:0] hd;
        @(negedge clk);
        ins_valid = (($urandom % 100) < p_ins);
        if (ins_valid) begin
            do begin
                key_ctr = (key_ctr + 1) % (1 << (AW + TW));
            end while (present(AW'(key_ctr >> TW), TW'(key_ctr)));
            ins_asid  = AW'(key_ctr >> TW);
            ins_tag   = TW'(key_ctr);
            ins_dirty = SB'($urandom);
        end
        cfg_we    = (($urandom % 50) == 0);
        cfg_wt    = CW'($urandom % (E + 1));
        chan_idle = (($urandom % 100) < p_idle);
        cb_ready  = (($urandom % 100) < 70);

        disp    = (cnt == E) && (md[E-1] != 0);
        e_ready = !disp;
        e_cbv = 1'b0; tgt = 0; esub = 0;
        if (ins_valid && disp) begin
            e_cbv = 1'b1; tgt = E - 1;
        end else if (chan_idle) begin
            for (int i = 0; i < cnt; i++)
                if (i < wt && md[i] != 0) begin e_cbv = 1'b1; tgt = i; end
        end
        if (e_cbv) for (int s = SB - 1; s >= 0; s--) if (md[tgt][s]) esub = s;

        lk_valid = (($urandom % 100) < p_lk);
        if (lk_valid) begin
            int r = $urandom % 10;
            if (e_cbv && r < 4) begin
                lk_asid = ma[tgt]; lk_tag = mt[tgt];   // R9 provoke same-cycle clear and hit
            end else if (cnt > 0 && r < 8) begin
                int k = $urandom % cnt;
                lk_asid = ma[k]; lk_tag = mt[k];
            end else begin
                lk_asid = AW'($urandom); lk_tag = TW'($urandom);
            end
        end
        #1;
        check("R7 ins_ready", ins_ready, e_ready);
        check(disp && ins_valid ? "R7 cb_valid" : (chan_idle ? "R5 cb_valid" : "R6 cb_valid"),
              cb_valid, e_cbv);
        if (e_cbv && cb_valid) begin
            check("R5 cb_asid", cb_asid, ma[tgt]);
            check("R5 cb_tag", cb_tag, mt[tgt]);
            check("R5 cb_sub", cb_sub, esub);
        end
        check("R3 rs_valid", rs_valid, pv[LAT-1]);
        check("R3 rs_hit", rs_hit, ph[LAT-1]);
        check("R2 R4 rs_slot", rs_slot, ps[LAT-1]);
        check("R9 rs_dirty", rs_dirty, pd[LAT-1]);

        // model update: clear, remove, insert (R10), threshold (R8)
        if (e_cbv && cb_ready) md[tgt][esub] = 1'b0;
        hit = 1'b0; hi = 0; hd = '0;
        if (lk_valid)
            for (int i = 0; i < cnt; i++)
                if (ma[i] == lk_asid && mt[i] == lk_tag) begin hit = 1'b1; hi = i; hd = md[i]; end
        if (hit) begin
            for (int j = hi; j < cnt - 1; j++) begin
                ma[j] = ma[j+1]; mt[j] = mt[j+1]; md[j] = md[j+1];
            end
            cnt--;
        end
        if (ins_valid && e_ready) begin
            for (int j = (cnt < E ? cnt : E - 1); j >= 1; j--) begin
                ma[j] = ma[j-1]; mt[j] = mt[j-1]; md[j] = md[j-1];
            end
            ma[0] = ins_asid; mt[0] = ins_tag; md[0] = ins_dirty;
            if (cnt < E) cnt++;
        end
        if (cfg_we) wt = int'(cfg_wt);
        for (int j = LAT - 1; j >= 1; j--) begin
            pv[j] = pv[j-1]; ph[j] = ph[j-1]; ps[j] = ps[j-1]; pd[j] = pd[j-1];
        end
        pv[0] = lk_valid; ph[0] = hit; ps[0] = hit ? hi : 0; pd[0] = hit ? hd : '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < LAT; j++) begin pv[j] = 0; ph[j] = 0; ps[j] = 0; pd[j] = '0; end
        for (int j = 0; j < E; j++) begin ma[j] = '0; mt[j] = '0; md[j] = '0; end
        chan_idle = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 ins_ready", ins_ready, 1);
        check("R1 cb_valid", cb_valid, 0);
        check("R1 rs_valid", rs_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ins_ready after release", ins_ready, 1);
        check("R1 rs_valid after release", rs_valid, 0);
        // fill with channel busy: write-back pile-up and displacement (R7, R6)
        for (int c = 0; c < 3000; c++) step(80, 10, 40);
        // balanced traffic with threshold changes (R8) and same-cycle events (R9, R10)
        for (int c = 0; c < 4000; c++) step(50, 50, 60);
        // idle channel drains write-through region (R5)
        for (int c = 0; c < 3000; c++) step(30, 90, 50);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule